// File: doc/BRIEF.md
# Serial Bus Link Register Bank

This block is the register bank of a link-layer controller for a serial bus. A 32-bit bus reaches it through a 16-bit byte offset. Writes take effect at the clock edge. Reads are combinational from the addressed register. Behind the bank sits a model of sixteen 8-bit PHY registers. Software reaches them through a single command-style access register. Software writes a command word with a read or write request flag. A small state machine runs the operation on the next clock edge. It clears the request flag and, for a read, returns the PHY data into the same word. The bank also holds three interrupt status/mask pairs, which drive a single interrupt line. It has fixed identification words, a control word whose bit 23 clears itself, a clock-ready word, and two storage words for DMA control.

The access state machine has three states. ACC_IDLE waits for a command. ACC_PHY_WR updates the selected PHY register and clears the write flag and the low half of the access word. ACC_PHY_RD merges the PHY data and index into the access word, clears the read flag, and may raise the read-done interrupt. A bus write to offset 0x14 selects the transition. Bit 30 set goes to ACC_PHY_WR. Otherwise bit 31 set goes to ACC_PHY_RD. Otherwise the machine stays in ACC_IDLE. Both work states always return to ACC_IDLE on the following edge, unless a new command arrives in that same cycle.

Top module: `link_regbank`

## Requirements
- R1: Offset 0x0000 always reads 0xFFC00001 and offset 0x007C always reads 0x10000001; writes to them have no effect.
- R2: Offset 0x0010 always reads 0x00000008, whatever is written to it.
- R3: Offset 0x0008 stores the written word, except that bit 23 always reads 0.
- R4: Writing offset 0x0014 stores the word. If bit 30 is set, PHY register [bits 11:8] receives bits 7:0. One cycle later, bit 30 and bits 15:0 of the access word read 0. With neither bit 30 nor bit 31 set, the word simply reads back.
- R5: If bit 31 is set and bit 30 is clear, one cycle later bit 31 reads 0. The PHY register selected by bits 27:24 is ORed into bits 7:0, and that index is ORed into bits 11:8.
- R6: When bits 30 and 31 are both set, only the PHY write is performed, and bit 31 stays set.
- R7: When a PHY read completes and mask 0 (offset 0x0024) bit 30 is set, status 0 (offset 0x0020) bit 30 becomes 1 and irq rises. With that mask bit clear, status is untouched.
- R8: Status registers at 0x0020, 0x0028 and 0x0030 are write-1-to-clear: each 1 written clears that bit, and 0 bits leave it unchanged.
- R9: Mask registers at 0x0024, 0x002C and 0x0034 are read/write. irq is high exactly when some status bit and its mask bit are both 1 in any pair.
- R10: Offsets 0x00B8 and 0x0138 are plain 32-bit read/write storage.
- R11: Reset clears every stored register and all sixteen PHY registers to zero.
- R12: Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 16 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt, OR of masked status bits |

## Verification
Plain register writes become visible at the edge that samples the strobe, so a read at the next falling edge shows them. PHY commands take one more edge: the write edge loads the command, and the following edge completes it and sets the status bit. irq follows the status combinationally in that same cycle. Every bench write therefore waits two rising edges before it reads back at a falling edge. That delay covers both the plain registers and the PHY commands, and the checker's properties use the matching one-cycle implication.

// File: rtl/link_regbank_pkg.sv
package link_regbank_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_PHY_WR = 2'd1,
        ACC_PHY_RD = 2'd2
    } acc_state_t;

    localparam logic [15:0] OFS_NODE_ID  = 16'h0000;
    localparam logic [15:0] OFS_CTRL0    = 16'h0008;
    localparam logic [15:0] OFS_CTRL2    = 16'h0010;
    localparam logic [15:0] OFS_PHY_ACC  = 16'h0014;
    localparam logic [15:0] OFS_ISTAT0   = 16'h0020;
    localparam logic [15:0] OFS_IMASK0   = 16'h0024;
    localparam int          IPAIR_STRIDE = 8;
    localparam logic [15:0] OFS_MAGIC    = 16'h007C;
    localparam logic [15:0] OFS_DMA0     = 16'h00B8;
    localparam logic [15:0] OFS_DMA1     = 16'h0138;

    localparam logic [31:0] NODE_ID_VAL  = 32'hFFC0_0001;
    localparam logic [31:0] MAGIC_VAL    = 32'h1000_0001;
    localparam logic [31:0] CTRL2_VAL    = 32'h0000_0008;

    localparam int CTRL0_SELFCLR_BIT = 23;
    localparam int ACC_WR_BIT        = 30;
    localparam int ACC_RD_BIT        = 31;
    localparam int ACC_WIDX_LSB      = 8;
    localparam int ACC_RIDX_LSB      = 24;
    localparam int RD_DONE_IRQ_BIT   = 30;

endpackage

// File: rtl/phy_file.sv
module phy_file #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    assign rdata = regs_q[ridx];
endmodule

// File: rtl/phy_access_fsm.sv
module phy_access_fsm
    import link_regbank_pkg::*;
#(
    parameter int DW     = 32,
    parameter int IDX_W  = 4,
    parameter int PDW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic [PDW-1:0]   phy_rdata,
    output logic [DW-1:0]    acc_q,
    output logic             phy_we,
    output logic [IDX_W-1:0] phy_widx,
    output logic [PDW-1:0]   phy_wdata,
    output logic [IDX_W-1:0] phy_ridx,
    output logic             rd_done
);
    localparam logic [DW-1:0] WR_CLR_MASK =
        (DW'(1) << ACC_WR_BIT) | DW'({(DW/2){1'b1}});
    localparam logic [DW-1:0] RD_CLR_MASK = DW'(1) << ACC_RD_BIT;

    acc_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // transitions: only a command write starts work
    always_comb begin
        state_d = ACC_IDLE;
        if (cmd_we) begin
            if (cmd_wdata[ACC_WR_BIT])      state_d = ACC_PHY_WR;
            else if (cmd_wdata[ACC_RD_BIT]) state_d = ACC_PHY_RD;
            else                            state_d = ACC_IDLE;
        end
    end

    // outputs
    always_comb begin
        phy_we  = 1'b0;
        rd_done = 1'b0;
        unique case (state_q)
            ACC_IDLE:   ;
            ACC_PHY_WR: phy_we  = 1'b1;
            ACC_PHY_RD: rd_done = 1'b1;
            default:    ;
        endcase
    end

    assign phy_widx  = acc_q[ACC_WIDX_LSB +: IDX_W];
    assign phy_wdata = acc_q[PDW-1:0];
    assign phy_ridx  = acc_q[ACC_RIDX_LSB +: IDX_W];

    // access word: bus write wins over completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (cmd_we) begin
            acc_q <= cmd_wdata;
        end else if (phy_we) begin
            acc_q <= acc_q & ~WR_CLR_MASK;
        end else if (rd_done) begin
            acc_q <= (acc_q & ~RD_CLR_MASK)
                   | DW'(phy_rdata)
                   | (DW'(phy_ridx) << ACC_WIDX_LSB);
        end
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int NUM = 3,
    parameter int DW  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM-1:0]         stat_w1c,
    input  logic [NUM-1:0]         mask_we,
    input  logic [DW-1:0]          wdata,
    input  logic [NUM-1:0][DW-1:0] set_bits,
    output logic [NUM-1:0][DW-1:0] stat_q,
    output logic [NUM-1:0][DW-1:0] mask_q,
    output logic                   irq
);
    logic [NUM-1:0] pend;

    for (genvar g = 0; g < NUM; g++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[g] <= '0;
                mask_q[g] <= '0;
            end else begin
                stat_q[g] <= (stat_q[g] & ~(stat_w1c[g] ? wdata : '0))
                           | set_bits[g];
                if (mask_we[g]) mask_q[g] <= wdata;
            end
        end
        assign pend[g] = |(stat_q[g] & mask_q[g]);
    end

    assign irq = |pend;
endmodule

// File: rtl/link_regbank.sv
module link_regbank
    import link_regbank_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_PAIRS = 3,
    parameter int PHY_IDX_W = 4,
    parameter int PHY_DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CTRL0_KEEP = ~(DATA_W'(1) << CTRL0_SELFCLR_BIT);

    logic [DATA_W-1:0] ctrl0_q, dma0_q, dma1_q, acc_q;
    logic              acc_we, phy_we, rd_done;
    logic [PHY_IDX_W-1:0] phy_widx, phy_ridx;
    logic [PHY_DW-1:0]    phy_wdata, phy_rdata;
    logic [NUM_PAIRS-1:0] stat_w1c, mask_we;
    logic [NUM_PAIRS-1:0][DATA_W-1:0] set_bits, stat_q, mask_q;

    assign acc_we = bus_we && (bus_addr == OFS_PHY_ACC);

    always_comb begin
        for (int i = 0; i < NUM_PAIRS; i++) begin
            stat_w1c[i] = bus_we && (bus_addr == OFS_ISTAT0 + ADDR_W'(i * IPAIR_STRIDE));
            mask_we[i]  = bus_we && (bus_addr == OFS_IMASK0 + ADDR_W'(i * IPAIR_STRIDE));
            set_bits[i] = '0;
        end
        if (rd_done && mask_q[0][RD_DONE_IRQ_BIT])
            set_bits[0] = DATA_W'(1) << RD_DONE_IRQ_BIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            dma0_q  <= '0;
            dma1_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_CTRL0) ctrl0_q <= bus_wdata & CTRL0_KEEP;
            if (bus_addr == OFS_DMA0)  dma0_q  <= bus_wdata;
            if (bus_addr == OFS_DMA1)  dma1_q  <= bus_wdata;
        end
    end

    phy_access_fsm #(.DW(DATA_W), .IDX_W(PHY_IDX_W), .PDW(PHY_DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(acc_we), .cmd_wdata(bus_wdata), .phy_rdata(phy_rdata),
        .acc_q(acc_q), .phy_we(phy_we), .phy_widx(phy_widx),
        .phy_wdata(phy_wdata), .phy_ridx(phy_ridx), .rd_done(rd_done)
    );

    phy_file #(.IDX_W(PHY_IDX_W), .DATA_W(PHY_DW)) u_phy (
        .clk(clk), .rst_n(rst_n),
        .we(phy_we), .widx(phy_widx), .wdata(phy_wdata),
        .ridx(phy_ridx), .rdata(phy_rdata)
    );

    irq_bank #(.NUM(NUM_PAIRS), .DW(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .stat_w1c(stat_w1c), .mask_we(mask_we), .wdata(bus_wdata),
        .set_bits(set_bits), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_NODE_ID: bus_rdata = NODE_ID_VAL;
            OFS_MAGIC:   bus_rdata = MAGIC_VAL;
            OFS_CTRL2:   bus_rdata = CTRL2_VAL;
            OFS_CTRL0:   bus_rdata = ctrl0_q;
            OFS_PHY_ACC: bus_rdata = acc_q;
            OFS_DMA0:    bus_rdata = dma0_q;
            OFS_DMA1:    bus_rdata = dma1_q;
            default:     bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (bus_addr == OFS_ISTAT0 + ADDR_W'(i * IPAIR_STRIDE)) bus_rdata = stat_q[i];
            if (bus_addr == OFS_IMASK0 + ADDR_W'(i * IPAIR_STRIDE)) bus_rdata = mask_q[i];
        end
    end
endmodule

// File: rtl/link_regbank_chk.sv
module link_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [15:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq,
    input logic [31:0] acc_q,
    input logic [31:0] ctrl0_q,
    input logic [31:0] stat0,
    input logic [31:0] mask0,
    input logic        phy_we,
    input logic        rd_done
);
    p_node_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 16'h0000) |-> (bus_rdata == 32'hFFC0_0001));

    p_ctrl2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 16'h0010) |-> (bus_rdata == 32'h0000_0008));

    p_ctrl0_selfclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 16'h0008) |=> (ctrl0_q == ($past(bus_wdata) & 32'hFF7F_FFFF)));

    p_phy_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_we && !(bus_we && bus_addr == 16'h0014)) |=> (!acc_q[30] && acc_q[15:0] == 16'h0));

    p_phy_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !(bus_we && bus_addr == 16'h0014)) |=> !acc_q[31]);

    p_both_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 16'h0014 && bus_wdata[30] && bus_wdata[31]) |=> (phy_we && !rd_done));

    p_rd_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && mask0[30]) |=> (stat0[30] && irq));

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 16'h0020 && !rd_done) |=> ((stat0 & $past(bus_wdata)) == 32'h0));

    p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 & mask0) != 32'h0) |-> irq);
endmodule

bind link_regbank link_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .acc_q(acc_q), .ctrl0_q(ctrl0_q), .stat0(stat_q[0]), .mask0(mask_q[0]),
    .phy_we(phy_we), .rd_done(rd_done)
);

// File: tb/test_link_regbank.sv
module test_link_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    link_regbank i_link_regbank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {write, offset, wdata, expected read, requirement}
    localparam int NV = 18;
    localparam logic [88:0] VEC [NV] = '{
        {1'b1, 16'h0008, 32'hFFFF_FFFF, 32'hFF7F_FFFF, 8'd3},  // R3
        {1'b1, 16'h0010, 32'h0000_0000, 32'h0000_0008, 8'd2},  // R2
        {1'b1, 16'h0010, 32'hFFFF_FFFF, 32'h0000_0008, 8'd2},
        {1'b1, 16'h0000, 32'h0000_1234, 32'hFFC0_0001, 8'd1},  // R1
        {1'b0, 16'h007C, 32'h0000_0000, 32'h1000_0001, 8'd1},
        {1'b1, 16'h0014, 32'h0000_1234, 32'h0000_1234, 8'd4},  // R4
        {1'b1, 16'h0014, 32'h4000_05A5, 32'h0000_0000, 8'd4},
        {1'b1, 16'h0014, 32'h8500_0000, 32'h0500_05A5, 8'd5},  // R5
        {1'b1, 16'h0014, 32'hC300_0377, 32'h8300_0000, 8'd6},  // R6
        {1'b1, 16'h0014, 32'h8300_0000, 32'h0300_0377, 8'd6},
        {1'b1, 16'h0024, 32'h0000_FFFF, 32'h0000_FFFF, 8'd9},  // R9
        {1'b1, 16'h002C, 32'h0000_1234, 32'h0000_1234, 8'd9},
        {1'b1, 16'h0034, 32'hABCD_0000, 32'hABCD_0000, 8'd9},
        {1'b1, 16'h00B8, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd10}, // R10
        {1'b1, 16'h0138, 32'hCAFE_F00D, 32'hCAFE_F00D, 8'd10},
        {1'b1, 16'h0040, 32'h1111_1111, 32'h0000_0000, 8'd12}, // R12
        {1'b0, 16'h0020, 32'h0000_0000, 32'h0000_0000, 8'd7},  // R7 mask bit clear
        {1'b0, 16'h00B8, 32'h0000_0000, 32'hDEAD_BEEF, 8'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // write spans one rising edge, then one more edge for PHY completion
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_rd(input string req, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        expect_rd("R11", 16'h0008, 32'h0);
        expect_rd("R11", 16'h0014, 32'h0);
        expect_rd("R11", 16'h0020, 32'h0);
        expect_rd("R11", 16'h0024, 32'h0);
        expect_rd("R11", 16'h0138, 32'h0);
        check("R11 irq", {31'h0, irq}, 32'h0);
        bus_write(16'h0014, 32'h8A00_0000);
        expect_rd("R11 phy", 16'h0014, 32'h0A00_0A00);

        for (int k = 0; k < NV; k++) begin
            logic [88:0] v;
            v = VEC[k];
            if (v[88]) bus_write(v[87:72], v[71:40]);
            expect_rd($sformatf("R%0d", v[7:0]), v[87:72], v[39:8]);
        end
        check("R9 irq idle", {31'h0, irq}, 32'h0);

        // R7: read completion with mask bit set
        bus_write(16'h0024, 32'h4000_0000);
        bus_write(16'h0014, 32'h8700_0000);
        expect_rd("R7", 16'h0020, 32'h4000_0000);
        check("R7 irq", {31'h0, irq}, 32'h1);
        // R8: zero bits leave status alone
        bus_write(16'h0020, 32'h0000_0001);
        expect_rd("R8", 16'h0020, 32'h4000_0000);
        // R9: mask gates irq
        bus_write(16'h0024, 32'h0);
        check("R9 masked", {31'h0, irq}, 32'h0);
        expect_rd("R9", 16'h0020, 32'h4000_0000);
        bus_write(16'h0024, 32'h4000_0000);
        check("R9 unmasked", {31'h0, irq}, 32'h1);
        // R8: clear
        bus_write(16'h0020, 32'h4000_0000);
        expect_rd("R8", 16'h0020, 32'h0);
        check("R8 irq", {31'h0, irq}, 32'h0);
        bus_write(16'h0028, 32'hFFFF_FFFF);
        expect_rd("R8", 16'h0028, 32'h0);
        expect_rd("R8", 16'h002C, 32'h0000_1234);

        // R11: mid-run reset clears PHY register 3
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        expect_rd("R11", 16'h00B8, 32'h0);
        bus_write(16'h0014, 32'h8300_0000);
        expect_rd("R11 phy", 16'h0014, 32'h0300_0300);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule